// File: doc/BRIEF.md
# I2C Target for a Six-Bit Non-Volatile Word Array

This block is the I2C target front end of a small non-volatile store. The store holds `2**AW` words of six bits and is modelled here as a register array. The block watches the synchronized SCL and SDA lines and answers on SDA through an open-drain enable: when `sda_oe_o` is high the pad pulls SDA low.

The block answers to a 7-bit address. The upper six bits of that address are a parameter, and the lowest bit is taken from the `a0_i` pin, so two copies can share one bus. After its address the host sends a command byte that opens the store, then a word-address byte.

- **Write:** one data byte follows the word address. The word is programmed only when the transaction ends in STOP. After that, `busy_o` holds the store closed for `BUSY_CYCLES` clock cycles, and no address is acknowledged during that window.
- **Read:** after the word address, the host issues a repeated START and the address with the read bit set. The block then returns the stored word.

The bus offers no back-pressure: the block never stretches SCL. Every byte is either ACKed at once or NACKed, and a NACK drops the block to idle until the next START.

Top module: `i2c_nvm_target`

## Requirements
- R1: The address byte (address in bits 7..1, read/write in bit 0, 1 = read) is ACKed only when bits 7..1 equal `{DEV_ID, a0_i}`; any other address is NACKed and the block stays silent until the next START.
- R2: The byte after a write address is ACKed only if it equals `CMD_SEL`; otherwise it is NACKed and every later byte of that transaction is NACKed.
- R3: The word-address byte and one data byte are ACKed. The word is selected by the low `AW` bits of the word-address byte. Data bits 5..0 are stored and bits 7..6 are ignored.
- R4: A word is programmed only when the transaction ends in STOP after the data byte's ACK. A STOP before the data byte completes, or a START after it, programs nothing and starts no busy window.
- R5: `busy_o` rises on the first clock after a committing STOP is detected and stays high for exactly `BUSY_CYCLES` clock cycles.
- R6: While `busy_o` is high, an address byte of either direction is NACKed, even when it matches.
- R7: A read (command, word address, repeated START, address with bit 0 = 1) is ACKed. The block then sends one byte MSB first: two zero bits followed by the stored six-bit word.
- R8: A read address that is not preceded in the same transaction by an accepted word address is NACKed.
- R9: A START at any point, including partway through a byte, discards the partial byte and restarts address reception.
- R10: After reset, `sda_oe_o` and `busy_o` are low and every stored word reads as zero.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (resolved bus) |
| a0_i | input | 1 | Address-select pin, lowest address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_o | output | 1 | High while a programming window runs |

## Verification
The bench builds the block with `BUSY_CYCLES` set to 300 instead of the default of several hundred thousand. This keeps the whole busy window within reach, so the bench can compare the exact rise and fall cycles and also try addresses while the window runs. `AW` is set to 4, so a word-address byte with set upper bits exercises the truncation to the low bits. The default `DEV_ID` and `CMD_SEL` are kept. Both values of `a0_i` are driven.

// File: rtl/i2cnv_pkg.sv
package i2cnv_pkg;
  // transfer phase of the target
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_CMD,
    PH_WORD,
    PH_DATA,
    PH_SEND
  } phase_e;

  localparam int WORD_W = 6;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cnv_line_mon.sv
module i2cnv_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // SDA edges while SCL stays high
  assign start_o = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cnv_word_store.sv
module i2cnv_word_store #(
  parameter int AW          = 6,
  parameter int WW          = 6,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [WW-1:0] rd_data,
  output logic          busy_o
);
  localparam int WORDS = 1 << AW;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  logic [WORDS-1:0][WW-1:0] mem;
  logic [CW-1:0]            remain;
  logic                     busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < WORDS; i++) begin
        if (wr_addr == AW'(i)) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // programming window timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      remain <= '0;
    end else if (wr_en) begin
      busy_q <= 1'b1;
      remain <= CW'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (remain == '0) busy_q <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_nvm_target.sv
module i2c_nvm_target
  import i2cnv_pkg::*;
#(
  parameter logic [5:0] DEV_ID      = 6'b101101,
  parameter logic [7:0] CMD_SEL     = 8'hC3,
  parameter int         AW          = 6,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a0_i,
  output logic sda_oe_o,
  output logic busy_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  phase_e             phase, next_ph, ack_next;
  logic [3:0]         bitcnt;
  logic [BYTE_W-1:0]  sr, tx, tx_load;
  logic               in_ack, oe, armed, pend, ack_ok, busy, wr_en;
  logic [AW-1:0]      word_q;
  logic [WORD_W-1:0]  pend_data, rd_word;

  i2cnv_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign wr_en = stop_det && pend;

  i2cnv_word_store #(.AW(AW), .WW(WORD_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(word_q),
    .wr_data(pend_data), .rd_addr(word_q), .rd_data(rd_word), .busy_o(busy)
  );

  assign tx_load = {2'b00, rd_word};

  // ACK decision for the byte just received
  always_comb begin
    ack_ok   = 1'b0;
    ack_next = PH_IDLE;
    case (phase)
      PH_DEV: begin
        ack_ok   = (sr[7:1] == {DEV_ID, a0_i}) && !busy && (!sr[0] || armed);
        ack_next = sr[0] ? PH_SEND : PH_CMD;
      end
      PH_CMD: begin
        ack_ok   = (sr == CMD_SEL);
        ack_next = PH_WORD;
      end
      PH_WORD: begin
        ack_ok   = 1'b1;
        ack_next = PH_DATA;
      end
      PH_DATA: begin
        ack_ok   = 1'b1;
        ack_next = PH_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      next_ph   <= PH_IDLE;
      bitcnt    <= '0;
      sr        <= '0;
      tx        <= '0;
      in_ack    <= 1'b0;
      oe        <= 1'b0;
      armed     <= 1'b0;
      pend      <= 1'b0;
      pend_data <= '0;
      word_q    <= '0;
    end else if (start_det) begin
      phase  <= PH_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      oe     <= 1'b0;
      pend   <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      oe     <= 1'b0;
      pend   <= 1'b0;
      armed  <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          sr     <= {sr[6:0], sda_i};
          bitcnt <= bitcnt + 4'd1;
        end else if (phase == PH_SEND) begin
          phase <= PH_IDLE;  // host ACK/NACK slot sampled
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          phase  <= next_ph;
          if (next_ph == PH_SEND) begin
            oe <= !tx_load[7];
            tx <= tx_load << 1;
          end else begin
            oe <= 1'b0;
          end
        end else if (phase == PH_SEND) begin
          if (bitcnt < 4'd8) begin
            oe <= !tx[7];
            tx <= tx << 1;
          end else begin
            oe <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          if (ack_ok) begin
            oe      <= 1'b1;
            in_ack  <= 1'b1;
            next_ph <= ack_next;
            if (phase == PH_WORD) begin
              word_q <= sr[AW-1:0];
              armed  <= 1'b1;
            end
            if (phase == PH_DATA) begin
              pend      <= 1'b1;
              pend_data <= sr[WORD_W-1:0];
            end
          end else begin
            phase <= PH_IDLE;
          end
        end
      end
    end
  end

  assign sda_oe_o = oe;
  assign busy_o   = busy;
endmodule

// File: rtl/i2cnv_checker.sv
module i2cnv_checker #(
  parameter int BUSY_CYCLES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_o,
  input logic start_det,
  input logic stop_det
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else run_len <= 0;
  end

  // R11: the enable moves only in the SCL low phase
  p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R5: a busy window opens only right after a STOP
  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det));

  // R5: window length measured by counter
  p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == BUSY_CYCLES));

  // R6: nothing is acknowledged during a window
  p_quiet_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  // R9: a START releases the line
  p_start_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);
endmodule

bind i2c_nvm_target i2cnv_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_i2cnv_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/test_i2c_nvm_target.sv
`timescale 1ns/1ps
module test_i2c_nvm_target;
  localparam logic [5:0] DEV_ID = 6'b101101;
  localparam logic [7:0] CMD    = 8'hC3;
  localparam int         AW     = 4;
  localparam int         BUSY   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, a0 = 1'b0;
  logic sda_oe, busy, sda_line;
  int   n_cmp = 0, n_bad = 0;
  int   cyc = 0;
  int   win_start = -1000000;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_nvm_target #(.DEV_ID(DEV_ID), .CMD_SEL(CMD), .AW(AW), .BUSY_CYCLES(BUSY)) i_i2c_nvm_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .a0_i(a0),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle reference: busy window and SDA phase rule
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic exp_busy;
      cyc = cyc + 1;
      exp_busy = (cyc > win_start) && (cyc <= win_start + BUSY);
      chk(busy == exp_busy, "R5 busy window", busy, exp_busy);
      chk(!(sda_oe != prev_oe && scl_m), "R11 sda change with scl high", sda_oe, prev_oe);
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2);
    sda_m = 1'b0; tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop(input bit commit);
    sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(2);
    sda_m = 1'b1;
    if (commit) win_start = cyc;
    tick(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(2); scl_m = 1'b1; tick(3); scl_m = 1'b0; tick(1);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2);
    b = sda_line; tick(1); scl_m = 1'b0; tick(1);
  endtask

  task automatic send_exp(input logic [7:0] v, input bit exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    chk(!s == exp_ack, tag, !s, exp_ack);
  endtask

  task automatic recv_exp(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(s);
      v[i] = s;
    end
    put_bit(1'b1);  // host NACK
    chk(v == exp, tag, v, exp);
  endtask

  task automatic do_write(input logic a, input logic [7:0] w, input logic [7:0] d);
    bus_start();
    send_exp({DEV_ID, a, 1'b0}, 1'b1, "R1 write address ack");
    send_exp(CMD, 1'b1, "R2 command ack");
    send_exp(w, 1'b1, "R3 word address ack");
    send_exp(d, 1'b1, "R3 data ack");
    bus_stop(1'b1);
  endtask

  task automatic do_read(input logic a, input logic [7:0] w, input logic [7:0] exp, input string tag);
    bus_start();
    send_exp({DEV_ID, a, 1'b0}, 1'b1, "R1 write address ack");
    send_exp(CMD, 1'b1, "R2 command ack");
    send_exp(w, 1'b1, "R3 word address ack");
    bus_start();
    send_exp({DEV_ID, a, 1'b1}, 1'b1, "R7 read address ack");
    recv_exp(exp, tag);
    bus_stop(1'b0);
  endtask

  task automatic wait_window();
    while (cyc <= win_start + BUSY) tick(1);
    tick(4);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    do_read(1'b0, 8'h03, 8'h00, "R10 unwritten word is zero");

    // write then lockout
    do_write(1'b0, 8'h03, 8'hEA);
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b0}, 1'b0, "R6 write address nack while busy");
    bus_stop(1'b0);
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b1}, 1'b0, "R6 read address nack while busy");
    bus_stop(1'b0);
    wait_window();
    do_read(1'b0, 8'h03, 8'h2A, "R3 R7 low six bits stored, top bits zero");

    // wrong a0
    bus_start();
    send_exp({DEV_ID, 1'b1, 1'b0}, 1'b0, "R1 address with other a0 nack");
    bus_stop(1'b0);

    // wrong command
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b0}, 1'b1, "R1 address ack");
    send_exp(CMD ^ 8'h01, 1'b0, "R2 wrong command nack");
    send_exp(8'h05, 1'b0, "R2 later byte nack");
    bus_stop(1'b0);

    // STOP before data: nothing stored, no window
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b0}, 1'b1, "R1 address ack");
    send_exp(CMD, 1'b1, "R2 command ack");
    send_exp(8'h05, 1'b1, "R3 word address ack");
    bus_stop(1'b0);
    tick(20);
    do_read(1'b0, 8'h05, 8'h00, "R4 early STOP programs nothing");

    // START after data: discarded
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b0}, 1'b1, "R1 address ack");
    send_exp(CMD, 1'b1, "R2 command ack");
    send_exp(8'h06, 1'b1, "R3 word address ack");
    send_exp(8'h11, 1'b1, "R3 data ack");
    bus_start();
    bus_stop(1'b0);
    tick(20);
    do_read(1'b0, 8'h06, 8'h00, "R4 START after data discards write");

    // read without word address
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b1}, 1'b0, "R8 read without word address nack");
    bus_stop(1'b0);

    // START mid-byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_write(1'b0, 8'h07, 8'h15);
    wait_window();
    do_read(1'b0, 8'h07, 8'h15, "R9 restart after partial byte");

    // word address truncated to AW bits
    do_write(1'b0, 8'h1C, 8'h3F);
    wait_window();
    do_read(1'b0, 8'h0C, 8'h3F, "R3 word address low bits select word");

    // a0 = 1
    a0 = 1'b1;
    do_write(1'b1, 8'h09, 8'h21);
    wait_window();
    do_read(1'b1, 8'h09, 8'h21, "R1 R7 device at a0=1");
    bus_start();
    send_exp({DEV_ID, 1'b0, 1'b0}, 1'b0, "R1 a0=0 address nack when pin high");
    bus_stop(1'b0);
    tick(10);
    finish_run();
  end
endmodule